// File: doc/BRIEF.md
# Bit-Serial Boolean Dot-Product Unit

This unit produces one entry of a Boolean matrix product: the OR, over a run of K steps, of the AND of an A bit and a B bit. A bit pairs arrive one per step. A arrives on an input-only pin. B arrives on a shared line that the unit later turns around to drive the result out, so the same wire carries the operand in and the answer back. The shared line is modelled at the block edge as a line input (`b_i`), a driven value (`c_o`) and an output enable (`c_oe_o`), which a pad or bus keeper combines into one wire.

A start pulse launches a fixed schedule with three parts. First a clear phase loads the accumulator loop from the shared line through a blocking stage. Then there is one 4-cycle slot per bit pair, in which the pair is captured, ANDed, ORed into the loop and carried round a three-stage recirculating loop. Last, the blocking stage opens outward and the result is driven for two cycles, with a done pulse on the second. A build-time option clears the loop from a constant. This shortens the clear phase to one cycle and leaves the line value out of it.

Top module: `bool_dot_serial`

## Requirements
- R1: The value in the done cycle on `c_o` is L OR (a_0 AND b_0) OR ... OR (a_(K-1) AND b_(K-1)), where L is the loop start value; the result is a single bit.
- R2: With FAST_CLEAR=0 the clear phase lasts 3 cycles, and L is the `b_i` value sampled in cycle 0, where cycle 0 is the first cycle after the clock edge that accepts start.
- R3: Bit pair s is sampled from `a_i`/`b_i` in cycle CL+4s, where CL is 3 (or 1 with FAST_CLEAR=1). Values on `a_i`/`b_i` in every other cycle have no effect on the result.
- R4: `c_oe_o` is high in exactly the two cycles CL+4K and CL+4K+1 of a run and low at all other times, including after reset. While it is low, `c_o` is 0.
- R5: `done_o` is high for exactly one cycle, cycle CL+4K+1, which makes a run CL+4K+2 cycles long (17 for K=3 with the line clear).
- R6: A start pulse that arrives in any cycle from cycle 0 to the done cycle is ignored. It does not restart or extend the run, and it does not cause a later run.
- R7: With FAST_CLEAR=1 the clear phase lasts 1 cycle and sets L to 0 whatever `b_i` holds (15 cycles in total for K=3).
- R8: A start in the first cycle after the done cycle is accepted and begins a new run.
- R9: Within a run, once the folded partial result is 1, each later OR stage also yields 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launches a run when the unit is idle |
| a_i | input | 1 | A operand bit (input-only line) |
| b_i | input | 1 | Shared line, inward direction: clear value and B operand bits |
| c_o | output | 1 | Shared line, outward value: the result |
| c_oe_o | output | 1 | Drive enable of the shared line |
| done_o | output | 1 | One-cycle pulse marking the valid result |

## Verification
The hardest situation to reach from the ports is a start pulse that lands while the unit is busy, and above all one in the final output cycle. A design that re-arms too early would accept that pulse and start a run the bench never asked for. The bench injects start pulses at random points inside runs and also in the done cycle itself. It then watches the enable for several idle cycles to confirm that no stray run appears. In the same runs it drives random noise on `a_i` and `b_i` in every cycle that is not a sampling slot, so a wrong slot position shows up as a wrong result. It also chains runs back to back so that the first idle cycle gets its own start.

// File: rtl/bool_dot_pkg.sv
package bool_dot_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CLR  = 2'd1,
    PH_ACC  = 2'd2,
    PH_OUT  = 2'd3
  } phase_t;

  // Boolean "multiply" of one operand pair
  function automatic logic bool_mul(input logic x, input logic y);
    return x & y;
  endfunction

  // Boolean "add" folding a product into the running value
  function automatic logic bool_add(input logic acc, input logic prod);
    return acc | prod;
  endfunction

  // Length of the clear phase for a given variant
  function automatic int unsigned clear_len(input bit fast);
    return fast ? 1 : 3;
  endfunction

  // Total cycles of one run, from acceptance to done inclusive
  function automatic int unsigned run_len(input int unsigned k, input bit fast);
    return clear_len(fast) + 4 * k + 2;
  endfunction

endpackage

// File: rtl/bool_dot_seq.sv
module bool_dot_seq
  import bool_dot_pkg::*;
#(
  parameter int K          = 3,
  parameter bit FAST_CLEAR = 1'b0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  output phase_t phase_o,
  output logic   accept_o,
  output logic   en_cap_o,
  output logic   en_and_o,
  output logic   en_or_o,
  output logic   en_hop_o,
  output logic   clr_grab_o,
  output logic   clr_load_o,
  output logic   out_grab_o,
  output logic   oe_o,
  output logic   done_o
);

  localparam int          CLR_LEN  = int'(clear_len(FAST_CLEAR));
  localparam int          STEP_W   = (K > 1) ? $clog2(K) : 1;
  localparam logic [1:0]  CLR_LAST = 2'(CLR_LEN - 1);
  localparam logic [1:0]  LOAD_SUB = FAST_CLEAR ? 2'd0 : 2'd1;
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(K - 1);

  phase_t            phase_q;
  logic [1:0]        sub_q;
  logic [STEP_W-1:0] step_q;
  logic              last_step;

  assign last_step = (step_q == STEP_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      sub_q   <= 2'd0;
      step_q  <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_CLR;
            sub_q   <= 2'd0;
          end
        end
        PH_CLR: begin
          if (sub_q == CLR_LAST) begin
            phase_q <= PH_ACC;
            sub_q   <= 2'd0;
            step_q  <= '0;
          end else begin
            sub_q <= sub_q + 2'd1;
          end
        end
        PH_ACC: begin
          sub_q <= sub_q + 2'd1;
          if (sub_q == 2'd3) begin
            if (last_step) begin
              phase_q <= PH_OUT;
              sub_q   <= 2'd0;
            end else begin
              step_q <= step_q + 1'b1;
            end
          end
        end
        PH_OUT: begin
          if (sub_q == 2'd1) begin
            phase_q <= PH_IDLE;
            sub_q   <= 2'd0;
          end else begin
            sub_q <= sub_q + 2'd1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    phase_o    = phase_q;
    accept_o   = (phase_q == PH_IDLE) && start_i;
    en_cap_o   = (phase_q == PH_ACC) && (sub_q == 2'd0);
    en_and_o   = (phase_q == PH_ACC) && (sub_q == 2'd1);
    en_or_o    = (phase_q == PH_ACC) && (sub_q == 2'd2);
    en_hop_o   = (phase_q == PH_ACC) && (sub_q == 2'd3);
    clr_grab_o = !FAST_CLEAR && (phase_q == PH_CLR) && (sub_q == 2'd0);
    clr_load_o = (phase_q == PH_CLR) && (sub_q == LOAD_SUB);
    out_grab_o = (phase_q == PH_OUT) && (sub_q == 2'd0);
    oe_o       = (phase_q == PH_OUT);
    done_o     = (phase_q == PH_OUT) && (sub_q == 2'd1);
  end

endmodule

// File: rtl/bool_dot_fold.sv
module bool_dot_fold
  import bool_dot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_cap_i,
  input  logic en_and_i,
  input  logic en_or_i,
  input  logic a_i,
  input  logic b_i,
  input  logic loop_i,
  output logic or_o
);

  logic in_a_q, in_b_q, and_q, or_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_a_q <= 1'b0;
      in_b_q <= 1'b0;
      and_q  <= 1'b0;
      or_q   <= 1'b0;
    end else begin
      if (en_cap_i) begin
        in_a_q <= a_i;
        in_b_q <= b_i;
      end
      if (en_and_i) and_q <= bool_mul(in_a_q, in_b_q);
      if (en_or_i)  or_q  <= bool_add(loop_i, and_q);
    end
  end

  assign or_o = or_q;

endmodule

// File: rtl/bool_dot_loop.sv
module bool_dot_loop #(
  parameter bit FAST_CLEAR = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_load_i,
  input  logic en_hop_i,
  input  logic en_mem_i,
  input  logic blk_i,
  input  logic or_i,
  output logic hop_o,
  output logic mem_o
);

  logic hop_q, mem_q, clr_src;

  generate
    if (FAST_CLEAR) begin : g_const_clr
      assign clr_src = 1'b0;
      logic unused_blk;
      assign unused_blk = blk_i;
    end else begin : g_line_clr
      assign clr_src = blk_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hop_q <= 1'b0;
      mem_q <= 1'b0;
    end else begin
      if (clr_load_i)    hop_q <= clr_src;
      else if (en_hop_i) hop_q <= or_i;
      if (en_mem_i)      mem_q <= hop_q;
    end
  end

  assign hop_o = hop_q;
  assign mem_o = mem_q;

endmodule

// File: rtl/bool_dot_gate.sv
module bool_dot_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_grab_i,
  input  logic out_grab_i,
  input  logic oe_i,
  input  logic line_i,
  input  logic hop_i,
  output logic blk_o,
  output logic c_o
);

  logic blk_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          blk_q <= 1'b0;
    else if (clr_grab_i) blk_q <= line_i;
    else if (out_grab_i) blk_q <= hop_i;
  end

  assign blk_o = blk_q;
  assign c_o   = oe_i ? blk_q : 1'b0;

endmodule

// File: rtl/bool_dot_serial.sv
module bool_dot_serial
  import bool_dot_pkg::*;
#(
  parameter int K          = 3,
  parameter bit FAST_CLEAR = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic a_i,
  input  logic b_i,
  output logic c_o,
  output logic c_oe_o,
  output logic done_o
);

  phase_t seq_phase;
  logic   seq_accept;
  logic   en_cap, en_and, en_or, en_hop;
  logic   clr_grab, clr_load, out_grab, line_oe;
  logic   or_val, hop_val, mem_val, blk_val;

  bool_dot_seq #(.K(K), .FAST_CLEAR(FAST_CLEAR)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .phase_o(seq_phase), .accept_o(seq_accept),
    .en_cap_o(en_cap), .en_and_o(en_and), .en_or_o(en_or), .en_hop_o(en_hop),
    .clr_grab_o(clr_grab), .clr_load_o(clr_load), .out_grab_o(out_grab),
    .oe_o(line_oe), .done_o(done_o)
  );

  bool_dot_fold u_fold (
    .clk(clk), .rst_n(rst_n),
    .en_cap_i(en_cap), .en_and_i(en_and), .en_or_i(en_or),
    .a_i(a_i), .b_i(b_i), .loop_i(mem_val), .or_o(or_val)
  );

  bool_dot_loop #(.FAST_CLEAR(FAST_CLEAR)) u_loop (
    .clk(clk), .rst_n(rst_n),
    .clr_load_i(clr_load), .en_hop_i(en_hop), .en_mem_i(en_cap),
    .blk_i(blk_val), .or_i(or_val), .hop_o(hop_val), .mem_o(mem_val)
  );

  bool_dot_gate u_gate (
    .clk(clk), .rst_n(rst_n),
    .clr_grab_i(clr_grab), .out_grab_i(out_grab), .oe_i(line_oe),
    .line_i(b_i), .hop_i(hop_val), .blk_o(blk_val), .c_o(c_o)
  );

  assign c_oe_o = line_oe;

endmodule

// File: rtl/bool_dot_chk.sv
module bool_dot_chk
  import bool_dot_pkg::*;
#(
  parameter int K          = 3,
  parameter bit FAST_CLEAR = 1'b0
) (
  input logic   clk,
  input logic   rst_n,
  input logic   c_oe_o,
  input logic   done_o,
  input phase_t phase,
  input logic   accept,
  input logic   en_or,
  input logic   mem_val,
  input logic   or_val
);

  localparam int TOTAL = int'(run_len(K, FAST_CLEAR));

  logic [15:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                run_cnt <= 16'hFFFF;
    else if (accept)           run_cnt <= 16'd0;
    else if (run_cnt != 16'hFFFF) run_cnt <= run_cnt + 16'd1;
  end

  AST_OE_RISE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c_oe_o) |=> c_oe_o); // R4
  AST_OE_TWO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (c_oe_o && $past(c_oe_o)) |=> !c_oe_o); // R4
  AST_DONE_IN_OE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (c_oe_o && $past(c_oe_o))); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R5
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_cnt == 16'(TOTAL - 1))); // R5
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ACC || phase == PH_OUT) |=> (phase != PH_CLR)); // R6
  AST_LOOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (en_or && mem_val) |=> or_val); // R9

endmodule

bind bool_dot_serial bool_dot_chk #(.K(K), .FAST_CLEAR(FAST_CLEAR)) u_chk (
  .clk(clk), .rst_n(rst_n), .c_oe_o(c_oe_o), .done_o(done_o),
  .phase(seq_phase), .accept(seq_accept), .en_or(en_or),
  .mem_val(mem_val), .or_val(or_val)
);

// File: tb/tb_bool_dot_serial.sv
module tb_bool_dot_serial;

  localparam int K = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st = 1'b0;
  logic sel = 1'b0;
  logic a = 1'b0;
  logic b = 1'b0;
  logic c_s, oe_s, done_s, c_f, oe_f, done_f;
  logic start_s, start_f;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   finished = 1'b0;

  always #2.5 clk = ~clk;

  assign start_s = st & ~sel;
  assign start_f = st & sel;

  bool_dot_serial #(.K(K), .FAST_CLEAR(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_s), .a_i(a), .b_i(b),
    .c_o(c_s), .c_oe_o(oe_s), .done_o(done_s)
  );

  bool_dot_serial #(.K(K), .FAST_CLEAR(1'b1)) dut_fast (
    .clk(clk), .rst_n(rst_n), .start_i(start_f), .a_i(a), .b_i(b),
    .c_o(c_f), .c_oe_o(oe_f), .done_o(done_f)
  );

  task automatic check_bit(input string req, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Independent model: any index where both bits are set makes the result 1
  function automatic logic exp_dot(input logic [K-1:0] av, input logic [K-1:0] bv, input logic start_val);
    logic r = start_val;
    for (int i = 0; i < K; i++)
      if (av[i] === 1'b1 && bv[i] === 1'b1) r = 1'b1;
    return r;
  endfunction

  task automatic do_run(input bit fast, input logic [K-1:0] av, input logic [K-1:0] bv,
                        input logic clr, input int poke1, input int poke2, input int nquiet);
    int   clen = fast ? 1 : 3;
    int   tot  = clen + 4 * K + 2;
    logic exp  = exp_dot(av, bv, fast ? 1'b0 : clr);
    logic oe, dn, cv;
    @(negedge clk);
    sel = fast; st = 1'b1; a = 1'($urandom); b = 1'($urandom);
    for (int n = 0; n < tot; n++) begin
      @(negedge clk);
      st = (n == poke1 || n == poke2);
      a  = 1'($urandom);
      b  = 1'($urandom);
      if (n == 0) b = clr;   // R2 line clear value; R7 ignored when fast
      for (int s = 0; s < K; s++)
        if (n == clen + 4 * s) begin a = av[s]; b = bv[s]; end  // R3
      oe = fast ? oe_f : oe_s;
      dn = fast ? done_f : done_s;
      cv = fast ? c_f : c_s;
      check_bit("R4", "c_oe_o", oe, (n >= tot - 2) ? 1'b1 : 1'b0);
      check_bit("R5", "done_o", dn, (n == tot - 1) ? 1'b1 : 1'b0);
      if (n < tot - 2) check_bit("R4", "c_o quiet", cv, 1'b0);
      if (n == tot - 1) check_bit(fast ? "R1 R7" : "R1 R2", "result", cv, exp);
    end
    for (int q = 0; q < nquiet; q++) begin
      @(negedge clk);
      st = 1'b0;
      check_bit("R6", "idle c_oe_o", fast ? oe_f : oe_s, 1'b0);
      check_bit("R6", "idle done_o", fast ? done_f : done_s, 1'b0);
    end
    if (nquiet == 0) st = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    check_bit("R4", "reset c_oe_o", oe_s, 1'b0);
    check_bit("R5", "reset done_o", done_s, 1'b0);
    check_bit("R4", "reset c_o", c_s, 1'b0);
    check_bit("R4", "reset fast c_oe_o", oe_f, 1'b0);
    check_bit("R5", "reset fast done_o", done_f, 1'b0);

    // Directed corner cases
    do_run(1'b0, 3'b000, 3'b000, 1'b0, -1, -1, 2);  // R1 all zero
    do_run(1'b0, 3'b000, 3'b000, 1'b1, -1, -1, 2);  // R2 line clear carries a 1
    do_run(1'b0, 3'b001, 3'b001, 1'b0, -1, -1, 2);  // R3 first slot only
    do_run(1'b0, 3'b100, 3'b100, 1'b0, -1, -1, 2);  // R3 last slot only
    do_run(1'b0, 3'b101, 3'b010, 1'b0, -1, -1, 2);  // R1 no coinciding pair
    do_run(1'b0, 3'b111, 3'b111, 1'b0, -1, -1, 2);  // R9 sticky after a 1
    do_run(1'b1, 3'b000, 3'b000, 1'b1, -1, -1, 2);  // R7 line value ignored
    do_run(1'b1, 3'b010, 3'b010, 1'b0, -1, -1, 2);  // R7 middle slot
    // R6: start pulses mid-run and in the done cycle
    do_run(1'b0, 3'b011, 3'b110, 1'b0, 5, 16, 20);
    do_run(1'b1, 3'b000, 3'b111, 1'b0, 0, 14, 20);
    // R8: back-to-back runs
    do_run(1'b0, 3'b010, 3'b011, 1'b0, -1, -1, 0);
    do_run(1'b0, 3'b000, 3'b011, 1'b0, -1, -1, 0);
    do_run(1'b1, 3'b100, 3'b100, 1'b1, -1, -1, 2);

    // Constrained random runs
    for (int r = 0; r < 60; r++) begin
      bit          f  = 1'($urandom);
      logic [K-1:0] av = K'($urandom);
      logic [K-1:0] bv = K'($urandom);
      logic        cl = ($urandom % 4 == 0);
      int          p1 = ($urandom % 3 == 0) ? int'($urandom % 17) : -1;
      do_run(f, av, bv, cl, p1, -1, int'($urandom % 3));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule